// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block pairs a serial transmitter and a serial receiver that share one oversampling bit-rate generator. A set of mode inputs chooses the baud clock source, one or two trailing stop bits on transmit, an optional multiprocessor flag bit, and a synchronous variant that sends and expects no stop bits. The transmitter takes a byte (plus a flag bit) through a valid/ready handshake and shifts it out LSB first. The receiver samples each bit at its centre and delivers a byte with a one-cycle strobe, along with a framing-error flag and the received flag bit.

The baud source is the system clock, the system clock divided by 16 or by 64, or a slow sub-clock enable taken at half rate (or at full rate when the low-power input is set). That source drives a bit-rate counter whose tick runs at sixteen times the baud rate. The mode inputs are sampled only between frames, so a change never corrupts a frame in flight. The receiver checks only the first stop bit. A low level straight after it is taken as the next start bit, so frames sent back to back are accepted.

Top module: `serial_mode_xcvr`

## Requirements
- R1: After reset `txLine` is 1, `txReady` is 1, and `rxValid`, `rxFrameErr`, `rxMpBit` and `rxData` are 0.
- R2: An accepted transmit byte is sent as a 0 start bit, then the 8 data bits LSB first, each bit lasting 16 bit-rate ticks; with `modeStop`=0 it is followed by exactly one 1 stop bit.
- R3: With `modeStop`=1 the transmitter sends two consecutive 1 stop bits after the character.
- R4: `txReady` stays 0 until the last configured stop bit (or, in synchronous mode, the last data bit) has been fully sent, and `txLine` is 1 whenever `txReady` is 1.
- R5: With `modeMp`=1, one extra bit carrying `txMpBit` is sent between the data and the stop bits. On receive this bit is stored in `rxMpBit`, which reads 0 for frames without it.
- R6: With `syncMode`=1 the frame is a start bit plus 8 data bits only; `modeStop` and `modeMp` have no effect, and received bytes never flag a framing error.
- R7: `clkSel` picks the baud source: 00 system clock, 01 sub-clock enable at half rate (every enable when `lowPower`=1), 10 system clock / 16, 11 system clock / 64. One bit lasts 16 × (`brDiv`+1) source ticks.
- R8: The receiver checks only the first stop bit. A 0 there sets `rxFrameErr` with the byte, and the receiver then waits for the line to return to 1 before hunting for a new start bit.
- R9: A 0 directly after a good first stop bit is taken as the start bit of the next frame, so back-to-back frames with one stop bit are each received.
- R10: A low pulse on `rxLine` is accepted as a start bit only if the line is still 0 on the 8th tick after it was seen. A shorter pulse produces no byte, and the receiver returns to idle.
- R11: Mode inputs are taken at frame boundaries only: a change of `modeStop` during a transmit frame does not alter that frame, but it applies to the next one.
- R12: `rxValid` is a one-cycle pulse per received frame, and `rxData` and the flags hold their values until the next frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 2 | Baud source select |
| lowPower | input | 1 | Use every sub-clock enable instead of every second one |
| subClkEn | input | 1 | Slow sub-clock enable pulse |
| brDiv | input | BR_W | Bit-rate divisor; tick period is brDiv+1 source ticks |
| modeStop | input | 1 | 0: one stop bit, 1: two stop bits (transmit only) |
| modeMp | input | 1 | Enable the multiprocessor flag bit |
| syncMode | input | 1 | Drop stop and flag bits |
| txData | input | DATA_W | Byte to transmit |
| txMpBit | input | 1 | Flag bit value to transmit |
| txValid | input | 1 | Transmit byte valid |
| txReady | output | 1 | Transmitter idle and able to accept |
| txLine | output | 1 | Serial transmit line, idles high |
| rxLine | input | 1 | Serial receive line |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | One-cycle strobe for a new byte |
| rxFrameErr | output | 1 | First stop bit of the last frame was 0 |
| rxMpBit | output | 1 | Flag bit of the last frame |

## Verification
The bench uses the default widths (8 data bits, 16 ticks per bit, 8-bit divisor) and mostly runs from the system clock with a divisor of 1. That gives a 32-cycle bit, short enough to run every framing mode, mid-frame mode changes, receive glitches, framing errors and back-to-back frames many times over. It then switches to the divide-by-16 source and to the sub-clock in both half-rate and full-rate form, at a divisor of 0, to time bits of 256, 64 and 32 cycles. Transmit bits are sampled at their centres, so a start offset of up to one tick period stays inside the tolerance.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [1:0] {
    CLK_SYS   = 2'b00,
    CLK_SUB   = 2'b01,
    CLK_DIV16 = 2'b10,
    CLK_DIV64 = 2'b11
  } clkSrcT;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_MP, TX_STOP1, TX_STOP2
  } txStateT;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_MP, RX_STOP, RX_TAIL, RX_HOLD
  } rxStateT;

  typedef enum logic [1:0] {
    LINE_MARK, LINE_SPACE, LINE_DATA, LINE_MPB
  } lineSelT;

  // control -> datapath strobes
  typedef struct packed {
    logic    txLoad;
    logic    txAdvance;
    lineSelT txLineSel;
    logic    rxShift;
    logic    rxMpCapture;
    logic    rxDeliver;
    logic    rxCheckStop;
    logic    rxMpUse;
  } strobeT;

endpackage

// File: rtl/smx_baud.sv
module smx_baud
  import smx_pkg::*;
#(
  parameter int BR_W       = 8,
  parameter int PRE_LO_LOG = 4,
  parameter int PRE_HI_LOG = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      clkSel,
  input  logic            lowPower,
  input  logic            subClkEn,
  input  logic [BR_W-1:0] brDiv,
  input  logic            allIdle,
  output logic            tick16
);

  clkSrcT                selAct;
  logic                  lpAct;
  logic [PRE_HI_LOG-1:0] preCnt;
  logic                  subHalf;
  logic                  srcTick;
  logic [BR_W-1:0]       brCnt;
  logic                  brWrap;

  // source selection is re-sampled only while both directions are idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAct <= CLK_SYS;
      lpAct  <= 1'b0;
    end else if (allIdle) begin
      selAct <= clkSrcT'(clkSel);
      lpAct  <= lowPower;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      subHalf <= 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (subClkEn) subHalf <= ~subHalf;
    end
  end

  always_comb begin
    unique case (selAct)
      CLK_SYS:   srcTick = 1'b1;
      CLK_SUB:   srcTick = subClkEn && (lpAct || subHalf);
      CLK_DIV16: srcTick = &preCnt[PRE_LO_LOG-1:0];
      default:   srcTick = &preCnt;
    endcase
  end

  assign brWrap = srcTick && (brCnt >= brDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brCnt  <= '0;
      tick16 <= 1'b0;
    end else begin
      tick16 <= brWrap;
      if (brWrap)       brCnt <= '0;
      else if (srcTick) brCnt <= brCnt + 1'b1;
    end
  end

  // R7: prescaled sources never give ticks on adjacent cycles
  a_r7_div_gap: assert property (@(posedge clk) disable iff (!rstN)
    (selAct[1] && selAct == $past(selAct) && tick16) |=> !tick16);

endmodule

// File: rtl/smx_ctrl.sv
module smx_ctrl
  import smx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick16,
  input  logic   txValid,
  input  logic   modeStop,
  input  logic   modeMp,
  input  logic   syncMode,
  input  logic   rxBit,
  output logic   txReady,
  output logic   allIdle,
  output strobeT strobe
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] SUB_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  txStateT          txState, txNext;
  logic [CNT_W-1:0] txSub;
  logic [IDX_W-1:0] txIdx;
  logic             txLatStop, txLatMp, txLatSync;
  logic             txBitEnd;

  rxStateT          rxState, rxNext;
  logic [CNT_W-1:0] rxSub;
  logic [IDX_W-1:0] rxIdx;
  logic             rxLatMp, rxLatSync;
  logic             rxStartMid, rxBitMid;

  assign txBitEnd   = tick16 && (txSub == SUB_LAST);
  assign rxStartMid = tick16 && (rxSub == SUB_MID);
  assign rxBitMid   = tick16 && (rxSub == SUB_LAST);

  always_comb begin
    txNext = txState;
    rxNext = rxState;
    strobe = '0;
    strobe.txLineSel = LINE_MARK;

    unique case (txState)
      TX_IDLE: if (txValid) begin
        txNext = TX_START;
        strobe.txLoad = 1'b1;
      end
      TX_START: if (txBitEnd) begin
        txNext = TX_DATA;
        strobe.txAdvance = 1'b1;
        strobe.txLineSel = LINE_DATA;
      end
      TX_DATA: if (txBitEnd) begin
        strobe.txAdvance = 1'b1;
        if (txIdx != IDX_LAST) begin
          strobe.txLineSel = LINE_DATA;
        end else if (txLatSync) begin
          txNext = TX_IDLE;
        end else if (txLatMp) begin
          txNext = TX_MP;
          strobe.txLineSel = LINE_MPB;
        end else begin
          txNext = TX_STOP1;
        end
      end
      TX_MP: if (txBitEnd) begin
        txNext = TX_STOP1;
        strobe.txAdvance = 1'b1;
      end
      TX_STOP1: if (txBitEnd) begin
        txNext = txLatStop ? TX_STOP2 : TX_IDLE;
        strobe.txAdvance = 1'b1;
      end
      TX_STOP2: if (txBitEnd) begin
        txNext = TX_IDLE;
        strobe.txAdvance = 1'b1;
      end
      default: txNext = TX_IDLE;
    endcase

    strobe.rxMpUse = rxLatMp && !rxLatSync;
    unique case (rxState)
      RX_IDLE: if (tick16 && !rxBit) rxNext = RX_START;
      RX_START: if (rxStartMid) rxNext = rxBit ? RX_IDLE : RX_DATA;
      RX_DATA: if (rxBitMid) begin
        strobe.rxShift = 1'b1;
        if (rxIdx == IDX_LAST) begin
          if (rxLatSync) begin
            rxNext = RX_TAIL;
            strobe.rxDeliver = 1'b1;
          end else begin
            rxNext = rxLatMp ? RX_MP : RX_STOP;
          end
        end
      end
      RX_MP: if (rxBitMid) begin
        strobe.rxMpCapture = 1'b1;
        rxNext = RX_STOP;
      end
      RX_STOP: if (rxBitMid) begin
        strobe.rxDeliver   = 1'b1;
        strobe.rxCheckStop = 1'b1;
        rxNext = rxBit ? RX_IDLE : RX_HOLD;
      end
      RX_TAIL: if (rxStartMid) rxNext = RX_IDLE;
      RX_HOLD: if (rxBit) rxNext = RX_IDLE;
      default: rxNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txSub     <= '0;
      txIdx     <= '0;
      txLatStop <= 1'b0;
      txLatMp   <= 1'b0;
      txLatSync <= 1'b0;
    end else begin
      txState <= txNext;
      if (txState == TX_IDLE || txBitEnd) txSub <= '0;
      else if (tick16)                    txSub <= txSub + 1'b1;
      if (strobe.txLoad) begin
        txIdx     <= '0;
        txLatStop <= modeStop;
        txLatMp   <= modeMp;
        txLatSync <= syncMode;
      end else if (txState == TX_DATA && txBitEnd) begin
        txIdx <= txIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      rxSub     <= '0;
      rxIdx     <= '0;
      rxLatMp   <= 1'b0;
      rxLatSync <= 1'b0;
    end else begin
      rxState <= rxNext;
      if (rxNext != rxState || rxBitMid) rxSub <= '0;
      else if (tick16)                   rxSub <= rxSub + 1'b1;
      if (rxState == RX_START && rxNext == RX_DATA) begin
        rxIdx     <= '0;
        rxLatMp   <= modeMp;
        rxLatSync <= syncMode;
      end else if (strobe.rxShift) begin
        rxIdx <= rxIdx + 1'b1;
      end
    end
  end

  assign txReady = (txState == TX_IDLE);
  assign allIdle = (txState == TX_IDLE) && (rxState == RX_IDLE);

  // R11: the stop-bit choice is frozen for the whole frame
  a_r11_stop_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (txState != TX_IDLE && $past(txState) != TX_IDLE) |-> $stable(txLatStop));

  // R10: a start bit that is high again at mid-bit is dropped
  a_r10_glitch_drop: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && rxStartMid && rxBit) |=> (rxState == RX_IDLE));

  // R9: a good first stop bit returns straight to start hunting
  a_r9_stop_rehunt: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_STOP && rxBitMid && rxBit) |=> (rxState == RX_IDLE));

  // R8: after a bad stop bit the receiver waits for a high line
  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_HOLD && !rxBit) |=> (rxState == RX_HOLD));

endmodule

// File: rtl/smx_dpath.sv
module smx_dpath
  import smx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txMpBit,
  input  logic              rxLine,
  output logic              txLine,
  output logic              rxBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              rxMpBit
);

  logic [DATA_W-1:0] txShiftReg;
  logic              txMpReg;
  logic [1:0]        rxSync;
  logic [DATA_W-1:0] rxShiftReg;
  logic [DATA_W-1:0] rxShiftNext;
  logic              rxMpStage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txMpReg    <= 1'b0;
      txLine     <= 1'b1;
    end else if (strobe.txLoad) begin
      txShiftReg <= txData;
      txMpReg    <= txMpBit;
      txLine     <= 1'b0;
    end else if (strobe.txAdvance) begin
      unique case (strobe.txLineSel)
        LINE_DATA: begin
          txLine     <= txShiftReg[0];
          txShiftReg <= {1'b0, txShiftReg[DATA_W-1:1]};
        end
        LINE_MPB:   txLine <= txMpReg;
        LINE_SPACE: txLine <= 1'b0;
        default:    txLine <= 1'b1;
      endcase
    end
  end

  assign rxBit       = rxSync[1];
  assign rxShiftNext = {rxBit, rxShiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync     <= 2'b11;
      rxShiftReg <= '0;
      rxMpStage  <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
      rxMpBit    <= 1'b0;
    end else begin
      rxSync  <= {rxSync[0], rxLine};
      rxValid <= strobe.rxDeliver;
      if (strobe.rxShift)     rxShiftReg <= rxShiftNext;
      if (strobe.rxMpCapture) rxMpStage  <= rxBit;
      if (strobe.rxDeliver) begin
        rxData     <= strobe.rxShift ? rxShiftNext : rxShiftReg;
        rxFrameErr <= strobe.rxCheckStop && !rxBit;
        rxMpBit    <= strobe.rxMpUse && rxMpStage;
      end
    end
  end

  // R12: the byte strobe never lasts two cycles
  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6: a frame delivered without a stop check carries no framing error
  a_r6_no_err_unchecked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxDeliver && !strobe.rxCheckStop) |=> !rxFrameErr);

endmodule

// File: rtl/serial_mode_xcvr.sv
module serial_mode_xcvr
  import smx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int BR_W       = 8,
  parameter int PRE_LO_LOG = 4,
  parameter int PRE_HI_LOG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        clkSel,
  input  logic              lowPower,
  input  logic              subClkEn,
  input  logic [BR_W-1:0]   brDiv,
  input  logic              modeStop,
  input  logic              modeMp,
  input  logic              syncMode,
  input  logic [DATA_W-1:0] txData,
  input  logic              txMpBit,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              rxMpBit
);

  logic   tick16;
  logic   allIdle;
  logic   rxBit;
  strobeT strobe;

  smx_baud #(
    .BR_W(BR_W), .PRE_LO_LOG(PRE_LO_LOG), .PRE_HI_LOG(PRE_HI_LOG)
  ) baud_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .lowPower(lowPower),
    .subClkEn(subClkEn), .brDiv(brDiv), .allIdle(allIdle), .tick16(tick16)
  );

  smx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txValid(txValid),
    .modeStop(modeStop), .modeMp(modeMp), .syncMode(syncMode),
    .rxBit(rxBit), .txReady(txReady), .allIdle(allIdle), .strobe(strobe)
  );

  smx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .txMpBit(txMpBit), .rxLine(rxLine), .txLine(txLine), .rxBit(rxBit),
    .rxData(rxData), .rxValid(rxValid), .rxFrameErr(rxFrameErr),
    .rxMpBit(rxMpBit)
  );

  // R4: an idle transmitter holds the line at mark
  a_r4_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R2: an accepted byte starts with a space
  a_r2_start_space: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txLine);

endmodule

// File: tb/serial_mode_xcvr_tb_top.sv
module serial_mode_xcvr_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       lowPower = 1'b0;
  logic       subClkEn = 1'b0;
  logic [7:0] brDiv = 8'd1;
  logic       modeStop = 1'b0;
  logic       modeMp = 1'b0;
  logic       syncMode = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txMpBit = 1'b0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       txLine;
  logic       rxLine = 1'b1;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxFrameErr;
  logic       rxMpBit;

  int nChecks = 0;
  int nFails  = 0;
  int rxCnt   = 0;
  logic [7:0] capData = '0;
  logic [7:0] prevData = '0;
  logic       capErr = 1'b0;
  logic       capMp = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) subClkEn <= ~subClkEn;

  serial_mode_xcvr dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .lowPower(lowPower),
    .subClkEn(subClkEn), .brDiv(brDiv), .modeStop(modeStop),
    .modeMp(modeMp), .syncMode(syncMode), .txData(txData),
    .txMpBit(txMpBit), .txValid(txValid), .txReady(txReady),
    .txLine(txLine), .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr), .rxMpBit(rxMpBit)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      prevData = capData;
      capData  = rxData;
      capErr   = rxFrameErr;
      capMp    = rxMpBit;
      rxCnt++;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // send one byte and check every bit at its centre
  task automatic txFrame(input logic [7:0] d, input logic mpb, input int bitCyc,
                         input bit withMp, input int nStop, input bit flipStop,
                         input string req);
    logic [11:0] exp;
    int nBits;
    int waited;
    exp = '1;
    exp[0] = 1'b0;
    nBits = 1;
    for (int i = 0; i < 8; i++) begin exp[nBits] = d[i]; nBits++; end
    if (withMp) begin exp[nBits] = mpb; nBits++; end
    for (int i = 0; i < nStop; i++) begin exp[nBits] = 1'b1; nBits++; end
    @(negedge clk);
    txData = d; txMpBit = mpb; txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    waited = 0;
    for (int k = 0; k < nBits; k++) begin
      while (waited < k * bitCyc + bitCyc / 2) begin @(negedge clk); waited++; end
      check($sformatf("%s tx bit %0d", req, k), 32'(txLine), 32'(exp[k]));
      if (flipStop && k == 3) modeStop = 1'b1;
    end
    check($sformatf("%s R4 busy in last bit", req), 32'(txReady), 32'd0);
    while (waited < nBits * bitCyc + 5) begin @(negedge clk); waited++; end
    check($sformatf("%s R4 ready after frame", req), 32'(txReady), 32'd1);
  endtask

  task automatic rxBits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxLine = bits[i];
      repeat (31) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rxLine = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 txLine", 32'(txLine), 32'd1);
    check("R1 txReady", 32'(txReady), 32'd1);
    check("R1 rxValid", 32'(rxValid), 32'd0);
    check("R1 rxFrameErr", 32'(rxFrameErr), 32'd0);
    check("R1 rxMpBit", 32'(rxMpBit), 32'd0);
    check("R1 rxData", 32'(rxData), 32'd0);
  endtask

  task automatic t_txModes();
    txFrame(8'hA5, 1'b0, 32, 1'b0, 1, 1'b0, "R2");
    modeStop = 1'b1;
    txFrame(8'h3C, 1'b0, 32, 1'b0, 2, 1'b0, "R3");
    modeStop = 1'b0; modeMp = 1'b1;
    txFrame(8'h0F, 1'b1, 32, 1'b1, 1, 1'b0, "R5 mp=1");
    txFrame(8'hF0, 1'b0, 32, 1'b1, 1, 1'b0, "R5 mp=0");
    syncMode = 1'b1; modeStop = 1'b1;
    txFrame(8'hC3, 1'b1, 32, 1'b0, 0, 1'b0, "R6");
    syncMode = 1'b0; modeStop = 1'b0; modeMp = 1'b0;
  endtask

  task automatic t_modeChange();
    txFrame(8'h96, 1'b0, 32, 1'b0, 1, 1'b1, "R11 mid-frame");
    txFrame(8'h69, 1'b0, 32, 1'b0, 2, 1'b0, "R11 next frame");
    modeStop = 1'b0;
  endtask

  task automatic t_clkSources();
    clkSel = 2'b10; brDiv = 8'd0;
    txFrame(8'h5A, 1'b0, 256, 1'b0, 1, 1'b0, "R7 div16");
    clkSel = 2'b01;
    txFrame(8'h81, 1'b0, 64, 1'b0, 1, 1'b0, "R7 sub half");
    lowPower = 1'b1;
    txFrame(8'h7E, 1'b0, 32, 1'b0, 1, 1'b0, "R7 sub full");
    lowPower = 1'b0; clkSel = 2'b00; brDiv = 8'd1;
    idle(8);
  endtask

  task automatic t_rxBasic();
    int c0;
    c0 = rxCnt;
    rxBits({6'h3F, 1'b1, 8'h3C, 1'b0}, 10);
    idle(24);
    check("R12 one strobe", 32'(rxCnt - c0), 32'd1);
    check("R2 rx data", 32'(capData), 32'h3C);
    check("R8 no error", 32'(capErr), 32'd0);
    check("R5 flag clear without mp", 32'(capMp), 32'd0);
    idle(100);
    check("R12 data held", 32'(rxData), 32'h3C);
    check("R12 strobe low", 32'(rxValid), 32'd0);
  endtask

  task automatic t_rxFrameErr();
    int c0;
    c0 = rxCnt;
    rxBits({6'h00, 1'b0, 8'h55, 1'b0}, 10);
    rxBits(16'h0000, 2);
    idle(40);
    check("R8 one byte for bad frame", 32'(rxCnt - c0), 32'd1);
    check("R8 error set", 32'(capErr), 32'd1);
    check("R8 data kept", 32'(capData), 32'h55);
    rxBits({6'h3F, 1'b1, 8'hA3, 1'b0}, 10);
    idle(24);
    check("R8 recovered count", 32'(rxCnt - c0), 32'd2);
    check("R8 recovered data", 32'(capData), 32'hA3);
    check("R8 error cleared", 32'(capErr), 32'd0);
  endtask

  task automatic t_rxBackToBack();
    int c0;
    c0 = rxCnt;
    modeStop = 1'b1;
    rxBits({6'h3F, 1'b1, 8'h12, 1'b0}, 10);
    rxBits({6'h3F, 1'b1, 8'h34, 1'b0}, 10);
    idle(24);
    check("R9 two frames", 32'(rxCnt - c0), 32'd2);
    check("R9 first byte", 32'(prevData), 32'h12);
    check("R9 second byte", 32'(capData), 32'h34);
    check("R9 no error", 32'(capErr), 32'd0);
    modeStop = 1'b0;
  endtask

  task automatic t_rxGlitch();
    int c0;
    c0 = rxCnt;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    idle(96);
    check("R10 glitch ignored", 32'(rxCnt - c0), 32'd0);
    rxBits({6'h3F, 1'b1, 8'h99, 1'b0}, 10);
    idle(24);
    check("R10 frame after glitch", 32'(rxCnt - c0), 32'd1);
    check("R10 data after glitch", 32'(capData), 32'h99);
  endtask

  task automatic t_rxMpSync();
    modeMp = 1'b1;
    rxBits({5'h1F, 1'b1, 1'b1, 8'hA0, 1'b0}, 11);
    idle(24);
    check("R5 rx flag 1", 32'(capMp), 32'd1);
    check("R5 rx data", 32'(capData), 32'hA0);
    rxBits({5'h1F, 1'b1, 1'b0, 8'h0B, 1'b0}, 11);
    idle(24);
    check("R5 rx flag 0", 32'(capMp), 32'd0);
    syncMode = 1'b1; modeStop = 1'b1;
    rxBits({7'h7F, 8'h6B, 1'b0}, 9);
    idle(40);
    check("R6 sync data", 32'(capData), 32'h6B);
    check("R6 sync no error", 32'(capErr), 32'd0);
    check("R6 sync no flag", 32'(capMp), 32'd0);
    syncMode = 1'b0; modeStop = 1'b0; modeMp = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_txModes();
    t_modeChange();
    t_clkSources();
    t_rxBasic();
    t_rxFrameErr();
    t_rxBackToBack();
    t_rxGlitch();
    t_rxMpSync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule